// File: doc/BRIEF.md
# ATA PIO Strobe Timing Engine

This block is the host side of a parallel ATA register and data port. Software or a surrounding controller first loads a timing configuration (an enable flag and three cycle counts: address setup before the strobe, strobe width, and hold after the strobe). It then issues command words. Each command names a drive register address, a direction, whether the data comes from or goes to a local register or a word stream, whether the access is one word or a multi-word burst, and a burst length in 16-bit words.

For each word the engine drives the address, waits the setup count, pulls the read or write strobe low for the strobe count, and keeps the address (and write data) steady for the hold count. Read data is captured on the last strobe cycle. A burst repeats the word access back to back until the word counter is exhausted. Status outputs tell the caller when the engine is busy, when each word has completed (transmit-ready), and when a captured register read is valid (data-available). At the end of a burst, transmit-ready is raised one cycle before busy falls, so a poller that sees busy low has already seen the final ready.

A new command accepted while a transfer runs aborts it and starts over, which lets a stuck access be cleared by a dummy command. With the enable flag off the engine is inert.

Top module: `ata_pio_engine`

## Requirements
- R1: After reset, busy, tr_rdy, data_avail, strm_take, strm_rvalid and ata_dout_en are 0, ata_rd_n and ata_wr_n are 1, and the enable flag is 0.
- R2: A word access starts with cfg_setup cycles in which the address is driven and both strobes are high; with cfg_setup = 0 the strobe starts in the first cycle after the command is accepted.
- R3: The strobe stays low for cfg_strobe cycles (a value of 0 is treated as 1); a read command (cmd_read = 1) uses ata_rd_n only, a write uses ata_wr_n only, and the two are never low together.
- R4: After the strobe, address and write data stay driven for cfg_hold cycles, and ata_addr equals the command address in every strobe cycle; one word therefore occupies cfg_setup + max(cfg_strobe,1) + cfg_hold cycles.
- R5: A register-destination read (cmd_read = 1, cmd_stream = 0) stores ata_din from the last strobe cycle in rd_data and raises data_avail in the cycle after that strobe cycle; data_avail clears when the next command is accepted.
- R6: A register-source write drives cmd_wdata on ata_dout with ata_dout_en = 1 throughout every strobe cycle.
- R7: With cmd_multi = 1 the command moves cmd_count words (a count of 0 means 2^CW words); with cmd_multi = 0 it moves exactly one word whatever cmd_count holds; busy stays 1 for the whole transfer plus one final cycle.
- R8: tr_rdy pulses once per completed word, in the cycle after the word's last cycle; after the final word tr_rdy is 1 while busy is still 1, and busy is 0 from the next cycle.
- R9: A stream-source write samples strm_wdata at the start of each word and pulses strm_take in the following cycle; a stream-destination read pulses strm_rvalid once per word with that word's data on rd_data, leaving data_avail untouched.
- R10: While the enable flag is 0, commands are ignored: busy stays 0 and both strobes stay high.
- R11: A command accepted while busy aborts the running transfer at once and starts the new one from its setup phase, with no further strobe of the old command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load the timing configuration |
| cfg_enable | input | 1 | Enable flag value |
| cfg_setup | input | TW | Setup cycles before the strobe |
| cfg_strobe | input | TW | Strobe-low cycles (0 acts as 1) |
| cfg_hold | input | TW | Hold cycles after the strobe |
| cmd_wr | input | 1 | Issue a command (one-cycle pulse) |
| cmd_addr | input | AW | Drive register address |
| cmd_read | input | 1 | 1 = read from drive, 0 = write to drive |
| cmd_stream | input | 1 | 1 = data via word stream, 0 = via register |
| cmd_multi | input | 1 | 1 = burst of cmd_count words |
| cmd_count | input | CW | Burst length in words, 0 = 2^CW |
| cmd_wdata | input | DW | Write word for register-source writes |
| strm_wdata | input | DW | Next stream word for stream writes |
| strm_take | output | 1 | Stream write word consumed |
| strm_rvalid | output | 1 | Stream read word valid on rd_data |
| busy | output | 1 | Transfer in progress |
| tr_rdy | output | 1 | A word has completed |
| data_avail | output | 1 | Register read result valid |
| rd_data | output | DW | Captured read word |
| ata_addr | output | AW | Drive register address lines |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_dout | output | DW | Write data to the drive |
| ata_dout_en | output | 1 | Write data output enable |
| ata_din | input | DW | Read data from the drive |

## Verification
The bench sweeps all five standard timing sets plus degenerate ones (zero setup, zero hold, zero strobe) over both directions, both data paths and burst lengths including the wrap-to-maximum count of 0, counting strobe, busy and ready cycles arithmetically. An engine that dropped busy in the same cycle as the final ready, or raised ready with busy already low, shows a mismatch in ready count against busy length. A zero strobe count not promoted to one cycle would skip the strobe entirely, and an off-by-one in the phase counter shifts the first strobe cycle or the total busy length. Aborting a burst with a write checks that no read strobe leaks out after the new command, and a disabled engine is checked for staying idle.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

endpackage

// File: rtl/ata_pio_phase_seq.sv
module ata_pio_phase_seq
    import ata_pio_pkg::*;
#(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          kill_i,
    input  logic [TW-1:0] setup_i,
    input  logic [TW-1:0] strobe_i,
    input  logic [TW-1:0] hold_i,
    output phase_e        phase_o,
    output logic          capture_o,
    output logic          word_end_o
);

    typedef struct packed {
        phase_e        ph;
        logic [TW-1:0] cnt;
    } seq_s;

    seq_s s_d, s_q;
    logic [TW-1:0] strb_m1;

    always_comb begin
        strb_m1    = (strobe_i == '0) ? '0 : strobe_i - 1'b1;
        capture_o  = (s_q.ph == PH_STROBE) && (s_q.cnt == '0);
        word_end_o = (capture_o && (hold_i == '0)) ||
                     ((s_q.ph == PH_HOLD) && (s_q.cnt == '0));
        s_d = s_q;
        case (s_q.ph)
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_STROBE;
                    s_d.cnt = strb_m1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (s_q.cnt == '0) begin
                    if (hold_i != '0) begin
                        s_d.ph  = PH_HOLD;
                        s_d.cnt = hold_i - 1'b1;
                    end else begin
                        s_d.ph  = PH_IDLE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == '0) s_d.ph = PH_IDLE;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            default: s_d.cnt = '0;
        endcase
        if (start_i) begin
            if (setup_i != '0) begin
                s_d.ph  = PH_SETUP;
                s_d.cnt = setup_i - 1'b1;
            end else begin
                s_d.ph  = PH_STROBE;
                s_d.cnt = strb_m1;
            end
        end
        if (kill_i) begin
            s_d.ph  = PH_IDLE;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph  <= PH_IDLE;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o = s_q.ph;

    // R3: a strobe phase with cycles left continues unless restarted or killed
    p_strobe_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_STROBE && s_q.cnt != '0 && !start_i && !kill_i) |=> (s_q.ph == PH_STROBE));

    // R2: setup always hands over to the strobe phase
    p_setup_to_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_SETUP && s_q.cnt == '0 && !start_i && !kill_i) |=> (s_q.ph == PH_STROBE));

endmodule

// File: rtl/ata_pio_word_ctr.sv
module ata_pio_word_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          multi_i,
    input  logic [CW-1:0] count_i,
    input  logic          step_i,
    input  logic          clear_i,
    output logic          last_o
);

    localparam int LW = CW + 1;

    logic [LW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (step_i && left_q != '0) left_d = left_q - 1'b1;
        if (clear_i) left_d = '0;
        if (load_i) begin
            if (!multi_i)            left_d = LW'(1);
            else if (count_i == '0)  left_d = LW'(1) << CW;
            else                     left_d = {1'b0, count_i};
        end
        last_o = (left_q == LW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    // R7: the remaining count never exceeds the largest burst
    p_left_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= (LW'(1) << CW));

endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
    import ata_pio_pkg::*;
#(
    parameter int TW = 5,
    parameter int CW = 16,
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_enable,
    input  logic [TW-1:0] cfg_setup,
    input  logic [TW-1:0] cfg_strobe,
    input  logic [TW-1:0] cfg_hold,
    input  logic          cmd_wr,
    input  logic [AW-1:0] cmd_addr,
    input  logic          cmd_read,
    input  logic          cmd_stream,
    input  logic          cmd_multi,
    input  logic [CW-1:0] cmd_count,
    input  logic [DW-1:0] cmd_wdata,
    input  logic [DW-1:0] strm_wdata,
    output logic          strm_take,
    output logic          strm_rvalid,
    output logic          busy,
    output logic          tr_rdy,
    output logic          data_avail,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] ata_addr,
    output logic          ata_rd_n,
    output logic          ata_wr_n,
    output logic [DW-1:0] ata_dout,
    output logic          ata_dout_en,
    input  logic [DW-1:0] ata_din
);

    typedef struct packed {
        logic          en;
        logic [TW-1:0] setup;
        logic [TW-1:0] strobe;
        logic [TW-1:0] hold;
        logic          active;
        logic          fin;
        logic [AW-1:0] addr;
        logic          rd;
        logic          strm;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          dav;
        logic          trdy;
        logic          take;
        logic          rvalid;
    } eng_s;

    eng_s   r_d, r_q;
    phase_e phase;
    logic   capture, word_end, last_word;
    logic   seq_start, seq_kill, ctr_load, ctr_step, ctr_clear;

    ata_pio_phase_seq #(.TW(TW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (seq_start),
        .kill_i     (seq_kill),
        .setup_i    (r_q.setup),
        .strobe_i   (r_q.strobe),
        .hold_i     (r_q.hold),
        .phase_o    (phase),
        .capture_o  (capture),
        .word_end_o (word_end)
    );

    ata_pio_word_ctr #(.CW(CW)) u_words (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (ctr_load),
        .multi_i (cmd_multi),
        .count_i (cmd_count),
        .step_i  (ctr_step),
        .clear_i (ctr_clear),
        .last_o  (last_word)
    );

    always_comb begin
        r_d        = r_q;
        r_d.trdy   = 1'b0;
        r_d.take   = 1'b0;
        r_d.rvalid = 1'b0;
        seq_start  = 1'b0;
        seq_kill   = 1'b0;
        ctr_load   = 1'b0;
        ctr_step   = 1'b0;
        ctr_clear  = 1'b0;

        if (cfg_wr) begin
            r_d.en     = cfg_enable;
            r_d.setup  = cfg_setup;
            r_d.strobe = cfg_strobe;
            r_d.hold   = cfg_hold;
        end

        if (!r_q.en) begin
            r_d.active = 1'b0;
            r_d.fin    = 1'b0;
            seq_kill   = 1'b1;
            ctr_clear  = 1'b1;
        end else if (cmd_wr) begin
            r_d.active = 1'b1;
            r_d.fin    = 1'b0;
            r_d.dav    = 1'b0;
            r_d.addr   = cmd_addr;
            r_d.rd     = cmd_read;
            r_d.strm   = cmd_stream;
            seq_start  = 1'b1;
            ctr_load   = 1'b1;
            if (!cmd_read) begin
                r_d.wdata = cmd_stream ? strm_wdata : cmd_wdata;
                r_d.take  = cmd_stream;
            end
        end else if (r_q.active) begin
            if (capture && r_q.rd) begin
                r_d.rdata = ata_din;
                if (r_q.strm) r_d.rvalid = 1'b1;
                else          r_d.dav    = 1'b1;
            end
            if (word_end) begin
                r_d.trdy = 1'b1;
                if (!last_word) begin
                    ctr_step  = 1'b1;
                    seq_start = 1'b1;
                    if (!r_q.rd && r_q.strm) begin
                        r_d.wdata = strm_wdata;
                        r_d.take  = 1'b1;
                    end
                end else begin
                    r_d.active = 1'b0;
                    r_d.fin    = 1'b1;
                    ctr_clear  = 1'b1;
                end
            end
        end else if (r_q.fin) begin
            r_d.fin = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = r_q.active | r_q.fin;
    assign tr_rdy      = r_q.trdy;
    assign data_avail  = r_q.dav;
    assign rd_data     = r_q.rdata;
    assign strm_take   = r_q.take;
    assign strm_rvalid = r_q.rvalid;
    assign ata_addr    = r_q.addr;
    assign ata_dout    = r_q.wdata;
    assign ata_rd_n    = !((phase == PH_STROBE) && r_q.rd);
    assign ata_wr_n    = !((phase == PH_STROBE) && !r_q.rd);
    assign ata_dout_en = (phase != PH_IDLE) && !r_q.rd;

    // R3: read and write strobes are never active together
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_rd_n && !ata_wr_n));

    // R4: address is steady across consecutive strobe cycles of one command
    p_addr_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ata_rd_n && $past(!ata_rd_n) && !$past(cmd_wr)) |-> $stable(ata_addr));

    // R6: write data is enabled whenever the write strobe is low
    p_dout_driven_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ata_wr_n |-> ata_dout_en);

    // R8: ready is never raised once busy has dropped
    p_rdy_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tr_rdy |-> busy);

    // R8: busy only falls after a ready cycle while enabled
    p_busy_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && r_q.en) |-> $past(tr_rdy));

    // R10: a disabled engine is idle in the next cycle
    p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.en |=> !busy);

endmodule

// File: tb/test_ata_pio_engine.sv
module test_ata_pio_engine;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 5;
    localparam int CW = 4;
    localparam int DW = 16;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0, cfg_enable = 1'b0;
    logic [TW-1:0] cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0;
    logic          cmd_wr = 1'b0, cmd_read = 1'b0, cmd_stream = 1'b0, cmd_multi = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [CW-1:0] cmd_count = '0;
    logic [DW-1:0] cmd_wdata = '0, strm_wdata = '0, ata_din = '0;
    logic          strm_take, strm_rvalid, busy, tr_rdy, data_avail;
    logic [DW-1:0] rd_data, ata_dout;
    logic [AW-1:0] ata_addr;
    logic          ata_rd_n, ata_wr_n, ata_dout_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_pio_engine #(.TW(TW), .CW(CW), .DW(DW), .AW(AW)) i_ata_pio_engine (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_enable(cfg_enable), .cfg_setup(cfg_setup),
        .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
        .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_read(cmd_read),
        .cmd_stream(cmd_stream), .cmd_multi(cmd_multi), .cmd_count(cmd_count),
        .cmd_wdata(cmd_wdata), .strm_wdata(strm_wdata),
        .strm_take(strm_take), .strm_rvalid(strm_rvalid),
        .busy(busy), .tr_rdy(tr_rdy), .data_avail(data_avail), .rd_data(rd_data),
        .ata_addr(ata_addr), .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n),
        .ata_dout(ata_dout), .ata_dout_en(ata_dout_en), .ata_din(ata_din)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input int idx);
        return 16'hC000 | (DW'(a) << 8) | DW'(idx);
    endfunction

    function automatic logic [DW-1:0] spat(input int idx);
        return 16'h5A00 + DW'(idx);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg(input bit en, input int s, input int t, input int h);
        cfg_wr = 1'b1; cfg_enable = en;
        cfg_setup = TW'(s); cfg_strobe = TW'(t); cfg_hold = TW'(h);
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic issue(input bit rd, input bit st, input bit mu, input int cnt,
                         input logic [AW-1:0] a, input logic [DW-1:0] wd);
        cmd_wr = 1'b1; cmd_read = rd; cmd_stream = st; cmd_multi = mu;
        cmd_count = CW'(cnt); cmd_addr = a; cmd_wdata = wd;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    int o_busy, o_first, o_low, o_rdlow, o_trdy, o_last_trdy, o_dav_k;
    int o_rv, o_bad_rv, o_take, o_bad_addr, o_bad_dout;

    task automatic observe(input bit rd, input bit st, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input int tl);
        logic [DW-1:0] exp_w;
        o_busy = 0; o_first = 0; o_low = 0; o_rdlow = 0; o_trdy = 0; o_last_trdy = 0;
        o_dav_k = 0; o_rv = 0; o_bad_rv = 0; o_take = 0; o_bad_addr = 0; o_bad_dout = 0;
        for (int k = 1; k < 3000; k++) begin
            if (!busy) break;
            o_busy++;
            if (!ata_rd_n || !ata_wr_n) begin
                o_low++;
                if (o_first == 0) o_first = k;
                if (ata_addr !== a) o_bad_addr++;
                if (!ata_rd_n) begin
                    o_rdlow++;
                    ata_din = pat(a, (o_low - 1) / tl);
                end
                if (!ata_wr_n) begin
                    exp_w = st ? spat((o_low - 1) / tl) : wd;
                    if (ata_dout !== exp_w || !ata_dout_en) o_bad_dout++;
                end
            end
            if (tr_rdy) begin o_trdy++; o_last_trdy = k; end
            if (data_avail && o_dav_k == 0) o_dav_k = k;
            if (strm_rvalid) begin
                if (rd_data !== pat(a, o_rv)) o_bad_rv++;
                o_rv++;
            end
            if (strm_take) begin
                o_take++;
                strm_wdata = spat(o_take);
            end
            @(negedge clk);
        end
    endtask

    task automatic run(input bit rd, input bit st, input bit mu, input int cnt,
                       input int s, input int t, input int h, input logic [AW-1:0] a);
        int n, tl, len;
        logic [DW-1:0] wd;
        n   = mu ? ((cnt == 0) ? (1 << CW) : cnt) : 1;
        tl  = (t == 0) ? 1 : t;
        len = s + tl + h;
        wd  = 16'h3300 + DW'(a) + DW'(s * 16 + t);
        cfg(1'b1, s, t, h);
        strm_wdata = spat(0);
        issue(rd, st, mu, cnt, a, wd);
        observe(rd, st, a, wd, tl);
        chk(o_busy == n * len + 1, "R4 R7 busy length", o_busy, n * len + 1);
        chk(o_first == s + 1, "R2 first strobe cycle", o_first, s + 1);
        chk(o_low == n * tl, "R3 strobe cycles", o_low, n * tl);
        chk(o_rdlow == (rd ? o_low : 0), "R3 strobe direction", o_rdlow, rd ? o_low : 0);
        chk(o_bad_addr == 0, "R4 address in strobe", o_bad_addr, 0);
        chk(o_trdy == n, "R8 ready pulses", o_trdy, n);
        chk(o_last_trdy == o_busy, "R8 ready before busy falls", o_last_trdy, o_busy);
        chk(tr_rdy == 1'b0, "R8 ready low after busy", tr_rdy, 0);
        if (rd && !st) begin
            chk(data_avail == 1'b1, "R5 data_avail set", data_avail, 1);
            chk(rd_data == pat(a, n - 1), "R5 read value", rd_data, pat(a, n - 1));
            if (n == 1) chk(o_dav_k == s + tl + 1, "R5 data_avail timing", o_dav_k, s + tl + 1);
        end
        if (rd && st) begin
            chk(o_rv == n, "R9 stream read words", o_rv, n);
            chk(o_bad_rv == 0, "R9 stream read data", o_bad_rv, 0);
            chk(data_avail == 1'b0, "R9 data_avail untouched", data_avail, 0);
        end
        if (!rd) begin
            chk(o_bad_dout == 0, st ? "R9 stream write data" : "R6 write data", o_bad_dout, 0);
            chk(o_take == (st ? n : 0), "R9 stream take count", o_take, st ? n : 0);
        end
    endtask

    function automatic int mode_s(input int m);
        case (m) 0: return 4; 1: return 2; default: return 1; endcase
    endfunction
    function automatic int mode_t(input int m);
        case (m) 0: return 19; 1: return 11; 2: return 6; default: return 5; endcase
    endfunction
    function automatic int mode_h(input int m);
        case (m) 0: return 4; 1: return 4; 2: return 2; 3: return 1; default: return 0; endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && tr_rdy == 0 && data_avail == 0, "R1 reset status", busy, 0);
        chk(ata_rd_n == 1 && ata_wr_n == 1 && ata_dout_en == 0, "R1 reset strobes", ata_rd_n, 1);
        chk(strm_take == 0 && strm_rvalid == 0, "R1 reset stream flags", strm_take, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: still disabled after reset, command ignored
        issue(1'b1, 1'b0, 1'b0, 0, 3'd1, 16'h0);
        bad = 0;
        for (int k = 0; k < 10; k++) begin
            if (busy || !ata_rd_n || !ata_wr_n) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R1 R10 disabled after reset", bad, 0);

        // standard timing sets, single register accesses
        for (int m = 0; m < 5; m++) begin
            for (int rd = 0; rd < 2; rd++)
                run(rd[0], 1'b0, 1'b0, 0, mode_s(m), mode_t(m), mode_h(m), AW'(m + 1));
        end
        // R7: single mode ignores the count
        run(1'b1, 1'b0, 1'b0, 5, 1, 2, 1, 3'd6);
        // zero strobe acts as one cycle (R3)
        run(1'b1, 1'b0, 1'b0, 0, 2, 0, 1, 3'd2);
        run(1'b0, 1'b0, 1'b0, 0, 0, 0, 0, 3'd7);

        // bursts over small configurations
        for (int c = 0; c < 3; c++) begin
            for (int ni = 0; ni < 5; ni++) begin
                for (int rd = 0; rd < 2; rd++) begin
                    for (int st = 0; st < 2; st++) begin
                        int cnt;
                        cnt = (ni == 4) ? 0 : ((ni == 3) ? 5 : ni + 1);
                        case (c)
                            0: run(rd[0], st[0], 1'b1, cnt, 0, 1, 0, AW'(ni));
                            1: run(rd[0], st[0], 1'b1, cnt, 1, 2, 1, AW'(ni + 2));
                            default: run(rd[0], st[0], 1'b1, cnt, 1, 5, 0, AW'(ni + 3));
                        endcase
                    end
                end
            end
        end

        // R11: abort a read burst with a single write
        cfg(1'b1, 1, 2, 1);
        issue(1'b1, 1'b0, 1'b1, 8, 3'd2, 16'h0);
        repeat (10) @(negedge clk);
        chk(busy == 1'b1, "R11 burst running before abort", busy, 1);
        issue(1'b0, 1'b0, 1'b0, 0, 3'd5, 16'h1234);
        observe(1'b0, 1'b0, 3'd5, 16'h1234, 2);
        chk(o_rdlow == 0, "R11 no old read strobe", o_rdlow, 0);
        chk(o_busy == 5, "R11 new command length", o_busy, 5);
        chk(o_trdy == 1, "R11 single ready", o_trdy, 1);
        chk(o_bad_dout == 0 && o_bad_addr == 0, "R11 new write data", o_bad_dout, 0);

        // R10: disabling makes commands ignored
        cfg(1'b0, 1, 2, 1);
        issue(1'b0, 1'b0, 1'b1, 3, 3'd4, 16'hBEEF);
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            if (busy || !ata_rd_n || !ata_wr_n || tr_rdy) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R10 disabled engine idle", bad, 0);
        run(1'b1, 1'b0, 1'b0, 0, 1, 3, 1, 3'd3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule